// File: doc/BRIEF.md
# Folded CORDIC Iteration Engine

This block runs the micro-rotation sequence of the CORDIC algorithm on a coordinate pair (x, y) and a residual angle z. One instance serves both directions of use. In rotation mode it turns the vector by the given angle, so z is driven toward zero. In vectoring mode it turns the vector onto the positive x axis, so y is driven toward zero and z collects the angle of the vector. Pre-rotation into the convergence range and correction of the CORDIC gain are done by neighbouring blocks.

The number of micro-rotations N and the latency L are separate parameters. When L is non-zero, the engine chains K = ceil(N/L) identical combinational step units. A small sequencer feeds their result back once per clock, so K micro-rotations complete each cycle. The work is padded to L*K iterations, and the padding iterations pass their operands through unchanged. When L is zero, the chain is fully unrolled and purely combinational.

Angles use a full-turn encoding: 2^AW codes span 360 degrees, the most negative code is -180 degrees, and arithmetic wraps modulo 2^AW.

Top module: `cordic_fold_engine`

## Requirements
- R1: While reset is held and after it is released, `done_o` is 0 and `x_o`, `y_o` and `z_o` are 0 until the first accepted start (when L > 0).
- R2: Iteration i updates the operands as x' = x - d*(y >>> i), y' = y + d*(x >>> i) and z' = z - d*A(i), with d = +1 or -1. The shifts are arithmetic on DW = XW+2 bit signed values, and the inputs are sign-extended to DW bits.
- R3: In rotation mode (`vect_i` = 0), d = +1 when bit AW-1 of the current z is 0, and d = -1 otherwise.
- R4: In vectoring mode (`vect_i` = 1), d = +1 when the current y is negative, and d = -1 otherwise.
- R5: A(i) equals round(atan(2^-i) * 2^AW / (2*pi)), and z is computed modulo 2^AW. N iterations with indices 0 to N-1 are applied to every operation.
- R6: With L > 0, K = ceil(N/L) steps are applied per cycle over L cycles. Iteration indices N to L*K-1 leave x, y and z unchanged, so the result equals that of exactly N iterations.
- R7: With L = N, one step unit is reused once per cycle, and the result equals that of N iterations.
- R8: With L = 0, the outputs are a combinational function of the inputs after N iterations, and `done_o` equals `start_i` in the same cycle.
- R9: With L > 0, a start accepted in cycle t produces a `done_o` pulse of exactly one cycle in cycle t+L, with the results valid on the outputs.
- R10: While a calculation is in progress, `start_i`, `vect_i`, `x_i`, `y_i` and `z_i` are ignored.
- R11: With L > 0, the outputs hold their last result while the engine is idle and no start is given.
- R12: A start given in the cycle in which `done_o` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled when idle |
| vect_i | input | 1 | 1 selects vectoring mode, 0 selects rotation mode; captured at start |
| x_i | input | XW | Signed x operand |
| y_i | input | XW | Signed y operand |
| z_i | input | AW | Angle operand, full-turn encoding |
| done_o | output | 1 | One-cycle result pulse |
| x_o | output | XW+2 | Signed x result |
| y_o | output | XW+2 | Signed y result |
| z_o | output | AW | Residual or accumulated angle, full-turn encoding |

## Verification
The assertions check on every cycle that `done_o` lands exactly L cycles after each accepted start and lasts one cycle. They also check that the engine's busy state follows only starts that arrive while it is idle, and that the outputs do not move while it is idle without a start. Only the bench scenarios show the arithmetic. These compare three latency variants (folded with dummy padding, one step per cycle, and fully unrolled) against a bit-exact reference over a grid of operands, angles and both modes. The same scenarios inject foreign starts and operands during busy cycles and chain each operation into the done cycle of the previous one.

// File: rtl/cordic_fold_engine.sv
module cordic_fold_engine #(
  parameter int XW = 12,
  parameter int AW = 14,
  parameter int N  = (AW - 2 > XW + 1) ? AW - 2 : XW + 1,
  parameter int L  = 5,
  localparam int DW = XW + 2,
  localparam int K  = (L == 0) ? N : (N + L - 1) / L,
  localparam int T  = (L == 0) ? N : L * K,
  localparam int IW = $clog2(T + 1),
  localparam int CW = (L < 2) ? 1 : $clog2(L)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 vect_i,
  input  logic signed [XW-1:0] x_i,
  input  logic signed [XW-1:0] y_i,
  input  logic        [AW-1:0] z_i,
  output logic                 done_o,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] y_o,
  output logic        [AW-1:0] z_o
);

  function automatic logic [AW-1:0] atan_c(input int i);
    real t, p, s;
    if (i >= N) return '0;
    if (i == 0) return AW'(1) << (AW - 3);
    t = 1.0;
    for (int b = 0; b < i; b++) t = t / 2.0;
    s = 0.0;
    p = t;
    for (int n = 0; n < 40; n++) begin
      if (n % 2 == 0) s = s + p / real'(2 * n + 1);
      else            s = s - p / real'(2 * n + 1);
      p = p * t * t;
    end
    return AW'($rtoi(s / 6.283185307179586 * (2.0 ** AW) + 0.5));
  endfunction

  logic                 busy, mode_r, mode_c;
  logic        [CW-1:0] cnt;
  logic        [IW-1:0] base;
  logic signed [DW-1:0] xr, yr;
  logic        [AW-1:0] zr;

  logic signed [DW-1:0] sx [K+1];
  logic signed [DW-1:0] sy [K+1];
  logic        [AW-1:0] sz [K+1];
  logic        [AW-1:0] atan_tab [T];

  for (genvar g = 0; g < T; g++) begin : g_tab
    localparam logic [AW-1:0] AC = atan_c(g);
    assign atan_tab[g] = AC;
  end

  assign mode_c = busy ? mode_r : vect_i;
  assign sx[0]  = busy ? xr : DW'(x_i);
  assign sy[0]  = busy ? yr : DW'(y_i);
  assign sz[0]  = busy ? zr : z_i;
  assign base   = busy ? IW'(cnt) * IW'(K) : '0;

  for (genvar j = 0; j < K; j++) begin : g_step
    logic        [IW-1:0] idx;
    logic                 dpos, skip;
    logic signed [DW-1:0] xsh, ysh;
    assign idx  = base + IW'(j);
    assign skip = idx >= IW'(N);
    assign dpos = mode_c ? sy[j][DW-1] : ~sz[j][AW-1];
    assign xsh  = sx[j] >>> idx;
    assign ysh  = sy[j] >>> idx;
    assign sx[j+1] = skip ? sx[j] : (dpos ? sx[j] - ysh : sx[j] + ysh);
    assign sy[j+1] = skip ? sy[j] : (dpos ? sy[j] + xsh : sy[j] - xsh);
    assign sz[j+1] = skip ? sz[j] : (dpos ? sz[j] - atan_tab[idx] : sz[j] + atan_tab[idx]);
  end

  if (L == 0) begin : g_comb
    assign busy   = 1'b0;
    assign mode_r = 1'b0;
    assign cnt    = '0;
    assign xr     = '0;
    assign yr     = '0;
    assign zr     = '0;
    assign done_o = start_i;
    assign x_o    = sx[K];
    assign y_o    = sy[K];
    assign z_o    = sz[K];
  end else begin : g_seq
    logic done_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy   <= 1'b0;
        cnt    <= '0;
        done_q <= 1'b0;
        mode_r <= 1'b0;
        xr     <= '0;
        yr     <= '0;
        zr     <= '0;
      end else begin
        done_q <= 1'b0;
        if (busy || start_i) begin
          xr <= sx[K];
          yr <= sy[K];
          zr <= sz[K];
        end
        if (!busy && start_i) begin
          mode_r <= vect_i;
          if (L == 1) done_q <= 1'b1;
          else begin
            busy <= 1'b1;
            cnt  <= CW'(1);
          end
        end else if (busy) begin
          if (cnt == CW'(L - 1)) begin
            busy   <= 1'b0;
            cnt    <= '0;
            done_q <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
    assign done_o = done_q;
    assign x_o    = xr;
    assign y_o    = yr;
    assign z_o    = zr;
  end

endmodule

// File: rtl/cordic_fold_engine_chk.sv
module cordic_fold_engine_chk #(
  parameter int L  = 5,
  parameter int DW = 14,
  parameter int AW = 14
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start_i,
  input logic                 busy,
  input logic                 done_o,
  input logic signed [DW-1:0] x_o,
  input logic signed [DW-1:0] y_o,
  input logic        [AW-1:0] z_o
);

  if (L > 0) begin : g_chk
    logic own_busy, exp_done;
    int   ccnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        own_busy <= 1'b0;
        exp_done <= 1'b0;
        ccnt     <= 0;
      end else begin
        exp_done <= 1'b0;
        if (!own_busy && start_i) begin
          if (L == 1) exp_done <= 1'b1;
          else begin
            own_busy <= 1'b1;
            ccnt     <= 1;
          end
        end else if (own_busy) begin
          if (ccnt == L - 1) begin
            own_busy <= 1'b0;
            exp_done <= 1'b1;
            ccnt     <= 0;
          end else begin
            ccnt <= ccnt + 1;
          end
        end
      end
    end

    // R9: done arrives exactly L cycles after an accepted start
    p_done_timing_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o == exp_done);

    // R10: starts during a calculation do not disturb the sequencer
    p_busy_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy == own_busy);

    // R11: idle without a start leaves the outputs untouched
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start_i) |=> ($stable(x_o) && $stable(y_o) && $stable(z_o)));

    if (L > 1) begin : g_pulse
      // R9: the done pulse lasts one cycle
      p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    end
  end

endmodule

bind cordic_fold_engine cordic_fold_engine_chk #(.L(L), .DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy(busy),
  .done_o(done_o), .x_o(x_o), .y_o(y_o), .z_o(z_o)
);

// File: tb/cordic_fold_engine_tb_top.sv
`timescale 1ns/1ps
module cordic_fold_engine_tb_top;
  localparam int XW = 12;
  localparam int AW = 14;
  localparam int N  = 13;
  localparam int DW = XW + 2;
  localparam int LF = 5;
  localparam int LN = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, vect = 1'b0;
  logic signed [XW-1:0] x_in = '0, y_in = '0;
  logic [AW-1:0] z_in = '0;

  logic done_f, done_n, done_c;
  logic signed [DW-1:0] xf, yf, xn, yn, xc, yc;
  logic [AW-1:0] zf, zn, zc;

  int total = 0, bad = 0;
  bit fin = 0;

  always #2.5 clk = ~clk;

  cordic_fold_engine #(.XW(XW), .AW(AW), .L(LF)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .vect_i(vect), .x_i(x_in), .y_i(y_in),
    .z_i(z_in), .done_o(done_f), .x_o(xf), .y_o(yf), .z_o(zf));
  cordic_fold_engine #(.XW(XW), .AW(AW), .L(LN)) dut_n_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .vect_i(vect), .x_i(x_in), .y_i(y_in),
    .z_i(z_in), .done_o(done_n), .x_o(xn), .y_o(yn), .z_o(zn));
  cordic_fold_engine #(.XW(XW), .AW(AW), .L(0)) dut_c_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .vect_i(vect), .x_i(x_in), .y_i(y_in),
    .z_i(z_in), .done_o(done_c), .x_o(xc), .y_o(yc), .z_o(zc));

  task automatic check(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int atan_ref(int i);
    return int'($floor($atan(2.0 ** (-i)) / (2.0 * 3.141592653589793) * (2.0 ** AW) + 0.5));
  endfunction

  longint ex, ey;
  int     ez;

  // R2 R3 R4 R5: bit-exact reference of N micro-rotations
  task automatic model(int xv, int yv, int zv, bit vm);
    longint x = xv, y = yv, xt;
    int z = zv & ((1 << AW) - 1);
    bit d;
    for (int i = 0; i < N; i++) begin
      d = vm ? (y < 0) : (((z >> (AW - 1)) & 1) == 0);
      xt = x;
      if (d) begin
        x = x - (y >>> i); y = y + (xt >>> i); z = (z - atan_ref(i)) & ((1 << AW) - 1);
      end else begin
        x = x + (y >>> i); y = y - (xt >>> i); z = (z + atan_ref(i)) & ((1 << AW) - 1);
      end
    end
    ex = x; ey = y; ez = z;
  endtask

  task automatic check_out(string tag, logic signed [DW-1:0] xo, logic signed [DW-1:0] yo,
                           logic [AW-1:0] zo);
    check({tag, " R2 x"}, longint'(xo), ex);
    check({tag, " R2 y"}, longint'(yo), ey);
    check({tag, " R5 z"}, longint'(zo), longint'(ez));
  endtask

  task automatic run_txn(int xv, int yv, int zv, bit vm);
    string mt;
    mt = vm ? "R4" : "R3";
    x_in = XW'(xv); y_in = XW'(yv); z_in = AW'(zv); vect = vm; start = 1'b1;
    model(xv, yv, zv, vm);
    #1;
    check("R8 done=start", done_c, 1);
    check_out({mt, " R8 L=0"}, xc, yc, zc);
    for (int c = 1; c <= LN; c++) begin
      @(negedge clk);
      x_in = XW'($urandom); y_in = XW'($urandom); z_in = AW'($urandom);
      vect = 1'($urandom);
      start = (c <= 4);  // R10: foreign starts while both engines are busy
      #1;
      check($sformatf("R9 done L=5 c=%0d", c), done_f, (c == LF));
      check($sformatf("R9 R12 done L=13 c=%0d", c), done_n, (c == LN));
      if (c == LF) check_out({mt, " R6 R10 L=5"}, xf, yf, zf);
      if (c == 6) check("R8 done follows start", done_c, 0);
      if (c == LN) begin
        check_out({mt, " R7 R10 L=13"}, xn, yn, zn);
        check_out("R11 hold L=5", xf, yf, zf);
      end
    end
    // returns inside the done cycle of L=13: next start hits it (R12)
  endtask

  initial begin
    int xs [9] = '{-2048, -1500, -700, -1, 0, 1, 650, 1400, 2047};
    int zs [6] = '{0, 2048, -4096, 4095, 1000, -8192};
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 done L=5", done_f, 0);
    check("R1 done L=13", done_n, 0);
    check("R1 x L=5", longint'(xf), 0);
    check("R1 y L=13", longint'(yn), 0);
    check("R1 z L=5", longint'(zf), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 x after release", longint'(xn), 0);
    for (int a = 0; a < 9; a++)
      for (int b = 0; b < 9; b++) begin
        for (int k = 0; k < 6; k++) run_txn(xs[a], xs[b], zs[k], 1'b0);
        run_txn(xs[a], xs[b], 321, 1'b1);
      end
    start = 1'b0;
    @(negedge clk);
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL R9 watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule